// File: doc/BRIEF.md
# Dot-Product Accelerator with Stalling Result Read

This block offloads a dot product from a host processor. The processor programs two operand array base addresses and an element count through a small register window. It then writes a go value to the control register. The block streams both arrays out of a shared data memory through its own read master. It multiplies matching 32-bit signed elements in a short pipeline and accumulates a 32-bit sum. Once the pipeline is full, one element pair is retired per clock.

Software does not poll. It issues a read of the sum register right after the go write. That read is held on the bus, with acknowledge low, until the final sum is valid. The same transaction then completes with the sum.

The slave side uses a simple request/acknowledge handshake. A transfer is presented with `s_req` and completes in the cycle in which `s_ack` is high. The acknowledge is combinational, so a transfer that is not stalled completes in the cycle it is presented. The read master drives both arrays in the same cycle: one address for array A and one for array B. It expects the data one cycle later.

Top module: `dotprod_accel`

## Requirements
- R1: The register window decodes byte offsets as follows: sum at 0x00, control/status at 0x08, base of array A at 0x0C, base of array B at 0x10, element count at 0x14. The three argument registers read back the value last written. Unmapped offsets read 0. Writes never stall.
- R2: A read of offset 0x08 returns busy in bit 0 and done in bit 1. Writing exactly the value 1 while idle starts a run: from the next cycle busy is 1 and done is 0. Any other written value is ignored. Done is set when the sum is valid and stays set until the next start.
- R3: The sum is the total of A[i]*B[i] for i from 0 to N-1 on 32-bit two's-complement integers. Only the low 32 bits of each product are kept, and the accumulation wraps modulo 2^32.
- R4: An element count of 0 finishes one cycle after the start with a sum of 0 and done set.
- R5: During a run, the master issues exactly N read cycles. Each read cycle presents one address for A and one for B, beginning at the programmed bases and advancing by 4 bytes per element. Read data is taken one cycle after the address. No read is issued while idle.
- R6: A read of the sum register while busy holds `s_ack` low until the run ends. The transfer then completes with the final sum.
- R7: A sum read issued immediately after the start write completes no more than N+4 cycles after the cycle in which the start write completed.
- R8: A start written while busy is ignored. The run in progress is neither restarted nor lengthened.
- R9: Writes to the argument registers during a run do not change the run in progress. They take effect at the next start.
- R10: After reset, status and sum read 0 and the master issues no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_req | input | 1 | Slave transfer request, held until acknowledged |
| s_we | input | 1 | Slave write (1) or read (0) |
| s_addr | input | OFFW (5) | Byte offset inside the register window |
| s_wdata | input | DW (32) | Slave write data |
| s_rdata | output | DW (32) | Slave read data, valid while `s_ack` is high |
| s_ack | output | 1 | Slave transfer completes this cycle |
| m_rd | output | 1 | Master read strobe for both arrays |
| m_addr_a | output | AW (32) | Byte address of the current A element |
| m_addr_b | output | AW (32) | Byte address of the current B element |
| m_rdata_a | input | DW (32) | A element, one cycle after the address |
| m_rdata_b | input | DW (32) | B element, one cycle after the address |

## Verification
The bench goes after the zero-length run. A design that waits for a product that never comes would hang the stalled sum read there. It checks runs of a single element and products whose low 32 bits overflow, which catch pipeline drain errors and a widened or saturating accumulator. It writes a second start and fresh arguments in the middle of a run. A design that restarted or read its arguments live would return a different sum or issue more master reads than N. Random arrays with random lengths confirm both the sum and the stall length against the N+4 bound. A design whose pipeline drains too late, or releases the stalled read one cycle early with a partial sum, fails these checks.

// File: rtl/dotprod_accel.sv
module dotprod_accel #(
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int OFFW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_req,
  input  logic            s_we,
  input  logic [OFFW-1:0] s_addr,
  input  logic [DW-1:0]   s_wdata,
  output logic [DW-1:0]   s_rdata,
  output logic            s_ack,
  output logic            m_rd,
  output logic [AW-1:0]   m_addr_a,
  output logic [AW-1:0]   m_addr_b,
  input  logic [DW-1:0]   m_rdata_a,
  input  logic [DW-1:0]   m_rdata_b
);
  localparam logic [OFFW-1:0] OFF_SUM = OFFW'(5'h00);
  localparam logic [OFFW-1:0] OFF_CTL = OFFW'(5'h08);
  localparam logic [OFFW-1:0] OFF_SA  = OFFW'(5'h0C);
  localparam logic [OFFW-1:0] OFF_SB  = OFFW'(5'h10);
  localparam logic [OFFW-1:0] OFF_LEN = OFFW'(5'h14);
  localparam logic [AW-1:0]   STEP    = AW'(DW / 8);

  logic [AW-1:0] base_a, base_b, ptr_a, ptr_b;
  logic [DW-1:0] len, remain, prod, acc;
  logic          busy, done, v1, v2;
  logic signed [2*DW-1:0] full_prod;

  wire sum_rd = s_req & ~s_we & (s_addr == OFF_SUM);
  assign s_ack = s_req & ~(sum_rd & busy);
  wire wr     = s_req & s_we & s_ack;
  wire start  = wr & (s_addr == OFF_CTL) & (s_wdata == DW'(1)) & ~busy;
  wire finish = busy & (remain == '0) & ~v1;

  assign m_rd      = busy & (remain != '0);
  assign m_addr_a  = ptr_a;
  assign m_addr_b  = ptr_b;
  assign full_prod = $signed(m_rdata_a) * $signed(m_rdata_b);

  always_comb begin
    case (s_addr)
      OFF_SUM: s_rdata = acc;
      OFF_CTL: s_rdata = {{(DW-2){1'b0}}, done, busy};
      OFF_SA:  s_rdata = DW'(base_a);
      OFF_SB:  s_rdata = DW'(base_b);
      OFF_LEN: s_rdata = len;
      default: s_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_a <= '0; base_b <= '0; len <= '0;
      ptr_a  <= '0; ptr_b  <= '0; remain <= '0;
      busy   <= 1'b0; done <= 1'b0;
      v1     <= 1'b0; v2 <= 1'b0;
      prod   <= '0; acc <= '0;
    end else begin
      if (wr && s_addr == OFF_SA)  base_a <= AW'(s_wdata);
      if (wr && s_addr == OFF_SB)  base_b <= AW'(s_wdata);
      if (wr && s_addr == OFF_LEN) len    <= s_wdata;
      v1 <= m_rd;
      v2 <= v1;
      if (v1) prod <= full_prod[DW-1:0];
      if (start) begin
        busy   <= 1'b1;
        done   <= 1'b0;
        remain <= len;
        ptr_a  <= base_a;
        ptr_b  <= base_b;
        acc    <= '0;
      end else begin
        if (m_rd) begin
          remain <= remain - 1'b1;
          ptr_a  <= ptr_a + STEP;
          ptr_b  <= ptr_b + STEP;
        end
        if (v2) acc <= acc + prod;
        if (finish) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dotprod_accel_chk.sv
module dotprod_accel_chk #(
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int OFFW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            s_req,
  input logic            s_we,
  input logic [OFFW-1:0] s_addr,
  input logic [DW-1:0]   s_wdata,
  input logic            s_ack,
  input logic            m_rd,
  input logic [AW-1:0]   m_addr_a,
  input logic [AW-1:0]   m_addr_b,
  input logic            busy,
  input logic            done
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  AST_WRITE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && s_we |-> s_ack); // R1
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R2
  AST_GO_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && s_we && s_addr == OFFW'(8) && s_wdata == DW'(1) && !busy |=> busy && !done); // R2
  AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    m_rd |-> busy); // R5
  AST_ADDR_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    m_rd && $past(m_rd) |-> m_addr_a == $past(m_addr_a) + STEP && m_addr_b == $past(m_addr_b) + STEP); // R5
  AST_SUM_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && !s_we && s_addr == '0 && busy |-> !s_ack); // R6
endmodule

bind dotprod_accel dotprod_accel_chk #(.DW(DW), .AW(AW), .OFFW(OFFW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
  .s_wdata(s_wdata), .s_ack(s_ack), .m_rd(m_rd), .m_addr_a(m_addr_a),
  .m_addr_b(m_addr_b), .busy(busy), .done(done)
);

// File: tb/tb_dotprod_accel.sv
module tb_dotprod_accel;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        s_req = 1'b0, s_we = 1'b0;
  logic [4:0]  s_addr = '0;
  logic [31:0] s_wdata = '0, s_rdata;
  logic        s_ack, m_rd;
  logic [31:0] m_addr_a, m_addr_b, m_rdata_a, m_rdata_b;
  logic [31:0] mem [0:1023];
  int checks = 0, errors = 0, rdcnt = 0;

  always #10 clk = ~clk;

  dotprod_accel dut (
    .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
    .s_wdata(s_wdata), .s_rdata(s_rdata), .s_ack(s_ack), .m_rd(m_rd),
    .m_addr_a(m_addr_a), .m_addr_b(m_addr_b),
    .m_rdata_a(m_rdata_a), .m_rdata_b(m_rdata_b)
  );

  always @(posedge clk) begin
    if (m_rd) begin
      m_rdata_a <= mem[m_addr_a[11:2]];
      m_rdata_b <= mem[m_addr_b[11:2]];
      rdcnt <= rdcnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [4:0] off, input logic [31:0] wd,
                      output logic [31:0] rd, output int waits);
    @(negedge clk);
    s_req = 1'b1; s_we = we; s_addr = off; s_wdata = wd; waits = 0;
    #2;
    while (!s_ack) begin
      @(negedge clk); #2;
      waits++;
    end
    rd = s_rdata;
    @(posedge clk); #1;
    s_req = 1'b0;
  endtask

  task automatic wr(input logic [4:0] off, input logic [31:0] wd);
    logic [31:0] d; int w;
    xfer(1'b1, off, wd, d, w);
  endtask

  task automatic rd(input logic [4:0] off, output logic [31:0] d, output int w);
    xfer(1'b0, off, '0, d, w);
  endtask

  function automatic logic [31:0] ref_dot(input int wa, input int wb, input int n);
    logic [31:0] s = '0;
    for (int i = 0; i < n; i++) s = s + mem[wa + i] * mem[wb + i];
    return s;
  endfunction

  task automatic run(input string req, input int wa, input int wb, input int n);
    logic [31:0] d; int w, c0;
    wr(5'h0C, 32'(wa * 4));
    wr(5'h10, 32'(wb * 4));
    wr(5'h14, 32'(n));
    c0 = rdcnt;
    wr(5'h08, 32'd1);
    rd(5'h00, d, w);
    chk({req, " sum (R3 R6)"}, d, ref_dot(wa, wb, n));
    chk({req, " latency <= N+4 (R7)"}, 32'(w + 1 <= n + 4), 32'd1);
    chk({req, " read count N (R5)"}, 32'(rdcnt - c0), 32'(n));
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d; int w, c0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    chk("R10 m_rd after reset", 32'(m_rd), 32'd0);
    rd(5'h08, d, w); chk("R10 status after reset", d, 32'd0);
    rd(5'h00, d, w); chk("R10 sum after reset", d, 32'd0);

    wr(5'h0C, 32'h0000_0100); wr(5'h10, 32'h0000_0200); wr(5'h14, 32'd7);
    rd(5'h0C, d, w); chk("R1 base A readback", d, 32'h100);
    rd(5'h10, d, w); chk("R1 base B readback", d, 32'h200);
    rd(5'h14, d, w); chk("R1 count readback", d, 32'd7);
    rd(5'h04, d, w); chk("R1 unmapped offset", d, 32'd0);

    mem[0] = 32'd3; mem[1] = -32'sd5; mem[2] = 32'd7; mem[3] = -32'sd2;
    mem[8] = 32'd4; mem[9] = 32'd6;   mem[10] = -32'sd1; mem[11] = -32'sd9;
    run("R3 directed signed", 0, 8, 4);

    mem[20] = 32'h7fff_ffff; mem[21] = 32'h8000_0000; mem[22] = 32'h1234_5678;
    mem[30] = 32'h7fff_ffff; mem[31] = 32'hffff_ffff; mem[32] = 32'h9abc_def0;
    run("R3 wrap", 20, 30, 3);

    run("R4 zero length", 5, 6, 0);
    rd(5'h08, d, w); chk("R4 done after zero length", d, 32'd2);
    run("R4 single element", 40, 41, 1);

    wr(5'h08, 32'd2);
    rd(5'h08, d, w); chk("R2 non-one value ignored", d, 32'd2);

    wr(5'h0C, 32'h0000_0400); wr(5'h10, 32'h0000_0800); wr(5'h14, 32'd50);
    c0 = rdcnt;
    wr(5'h08, 32'd1);
    rd(5'h08, d, w); chk("R2 busy after start", d, 32'd1);
    wr(5'h08, 32'd1);
    wr(5'h14, 32'd3);
    wr(5'h0C, 32'h0000_0000);
    rd(5'h00, d, w);
    chk("R8 R9 sum unaffected by mid-run writes", d, ref_dot(256, 512, 50));
    chk("R8 no restart, read count", 32'(rdcnt - c0), 32'd50);
    rd(5'h08, d, w); chk("R2 done after run", d, 32'd2);
    rd(5'h14, d, w); chk("R9 new count held for next start", d, 32'd3);

    for (int k = 0; k < 20; k++) begin
      int n, wa, wb;
      n  = (k == 0) ? 200 : int'($urandom_range(0, 200));
      wa = int'($urandom_range(0, 1023 - n));
      wb = int'($urandom_range(0, 1023 - n));
      run("R3 R7 random", wa, wb, n);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule